// File: doc/BRIEF.md
# Pipelined Subarray-Decoded Cache Lookup

This block is the read path of a set-associative cache whose tag and data storage are split into subarrays. The low-order bits of the set index pick one subarray, and only that subarray's row decoder is switched on for an access, so the others draw no decode power. The subarray choice is made one stage ahead of the row decode. This adds latency, but the path is pipelined over four stages so that a new lookup can enter on every cycle.

The stages are: choose the subarray; decode the row in that subarray and read the tags of every way; read the data word of every way while comparing the upper half of each stored tag; compare the lower half of each tag and steer the data word of the hitting way to the output. Each response carries a hit or a miss flag. Lines are written through a one-cycle fill port that stores the tag and all words of a line into a chosen way and marks that way valid. The default geometry is 8 KB, 4 ways, 64-byte lines and 32-bit words. This gives 32 sets spread over 4 subarrays, a 21-bit tag, set index bits addr[10:6] and word offset addr[5:2].

Top module: `slice_cache_lookup`

## Requirements
- R1: After reset no way of any set is valid, no response is pending, and every lookup reports a miss until a fill has written the way it needs.
- R2: A request accepted in cycle n yields resp_valid_o in cycle n+4. A request may be accepted in every cycle, and responses come back in request order.
- R3: tag_sub_en_o is zero or one-hot. In cycle n+1 after a request in cycle n, only bit addr[7:6] is set. With no request it is zero.
- R4: data_sub_en_o is high in cycle n+2, on the same bit that tag_sub_en_o showed in cycle n+1.
- R5: A hit requires a valid way whose stored 21-bit tag equals addr[31:11]. The response data is then word addr[5:2] of that way's line, and word k of a line is fill bits [32k+31:32k].
- R6: If only the upper tag half addr[31:21] matches a valid way, or only the lower half addr[20:11] matches, the lookup reports a miss.
- R7: Each response asserts exactly one of resp_hit_o and resp_miss_o. On a miss resp_data_o is zero, and both flags are low when resp_valid_o is low.
- R8: A fill writes tag fill_addr_i[31:11] and the line into set fill_addr_i[10:6], way fill_way_i, and marks that way valid, replacing any earlier content. A lookup accepted in any later cycle sees the new content. A lookup to another way of the same set that is already in flight is unaffected.
- R9: Byte offset bits addr[1:0] have no effect on the lookup result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Lookup request present this cycle |
| req_addr_i | input | ADDR_W (32) | Byte address of the lookup |
| fill_valid_i | input | 1 | Fill write this cycle |
| fill_addr_i | input | ADDR_W (32) | Address giving tag and set of the filled line |
| fill_way_i | input | WAY_W (2) | Way to overwrite |
| fill_line_i | input | LINE_W (512) | Full line, word k at bits [32k+31:32k] |
| resp_valid_o | output | 1 | Response present |
| resp_hit_o | output | 1 | Lookup hit |
| resp_miss_o | output | 1 | Lookup missed |
| resp_data_o | output | WORD_W (32) | Addressed word on a hit, zero on a miss |
| tag_sub_en_o | output | NUM_SUB (4) | Tag subarray row-decoder enable, stage 2 |
| data_sub_en_o | output | NUM_SUB (4) | Data subarray row-decoder enable, stage 3 |

## Verification
The first sweep issues back-to-back lookups to every set before any fill, so every response must be a miss. After all 128 lines are filled, a second sweep visits every set and way at the first, last and a varying word offset with changing byte offsets. This separates wrong way selection, wrong word steering, subarray and row mix-ups, and byte-offset leakage. Crafted tags that match only the upper half or only the lower half show whether the partial compare alone, or the completing compare alone, can produce a hit. Overwrites with a lookup to a neighbouring way already in flight check fill visibility, and a one-cycle shift of the enables or responses is caught because every cycle is compared against the expected pipeline position.

// File: rtl/slc_pkg.sv
package slc_pkg;
   // Default geometry of the lookup path
   localparam int unsigned DEF_ADDR_W      = 32;
   localparam int unsigned DEF_CACHE_BYTES = 8192;
   localparam int unsigned DEF_LINE_BYTES  = 64;
   localparam int unsigned DEF_WAYS        = 4;
   localparam int unsigned DEF_WORD_W      = 32;
   localparam int unsigned DEF_NUM_SUB     = 4;

   // Pipeline depth from request acceptance to response
   localparam int unsigned LOOKUP_LATENCY  = 4;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/slc_sub_decoder.sv
module slc_sub_decoder #(
   parameter int unsigned N = 4,
   localparam int unsigned IW = $clog2(N)
) (
   input  logic          en_i,
   input  logic [IW-1:0] idx_i,
   output logic [N-1:0]  sel_o
);
   for (genvar k = 0; k < N; k++) begin : g_line
      assign sel_o[k] = en_i && (idx_i == IW'(k));
   end
endmodule

// File: rtl/slc_way_cmp.sv
module slc_way_cmp #(
   parameter int unsigned WAYS = 4,
   parameter int unsigned W    = 11
) (
   input  logic [WAYS*W-1:0] stored_i,
   input  logic [W-1:0]      key_i,
   input  logic [WAYS-1:0]   qual_i,
   output logic [WAYS-1:0]   match_o
);
   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign match_o[w] = qual_i[w] && (stored_i[w*W +: W] == key_i);
   end
endmodule

// File: rtl/slc_tag_bank.sv
module slc_tag_bank #(
   parameter int unsigned ROWS  = 8,
   parameter int unsigned WAYS  = 4,
   parameter int unsigned TAG_W = 21,
   localparam int unsigned ROW_W = $clog2(ROWS),
   localparam int unsigned WAY_W = $clog2(WAYS),
   localparam int unsigned IDX_W = ROW_W + WAY_W
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  rd_en_i,
   input  logic [ROW_W-1:0]      rd_row_i,
   output logic [WAYS*TAG_W-1:0] rd_tag_o,
   output logic [WAYS-1:0]       rd_vld_o,
   input  logic                  wr_en_i,
   input  logic [ROW_W-1:0]      wr_row_i,
   input  logic [WAY_W-1:0]      wr_way_i,
   input  logic [TAG_W-1:0]      wr_tag_i
);
   logic [TAG_W-1:0]      tag_mem [ROWS*WAYS];
   logic [ROWS*WAYS-1:0]  vld_q;
   logic [IDX_W-1:0]      wr_idx;

   assign wr_idx = {wr_row_i, wr_way_i};

   always_ff @(posedge clk_i) begin
      if (wr_en_i) tag_mem[wr_idx] <= wr_tag_i;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)      vld_q <= '0;
      else if (wr_en_i) vld_q[wr_idx] <= 1'b1;
   end

   // Only the enabled subarray decodes a row and drives its sense outputs
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         rd_tag_o <= '0;
         rd_vld_o <= '0;
      end else if (rd_en_i) begin
         for (int w = 0; w < WAYS; w++) begin
            rd_tag_o[w*TAG_W +: TAG_W] <= tag_mem[{rd_row_i, WAY_W'(w)}];
            rd_vld_o[w]                <= vld_q[{rd_row_i, WAY_W'(w)}];
         end
      end
   end
endmodule

// File: rtl/slc_data_bank.sv
module slc_data_bank #(
   parameter int unsigned ROWS   = 8,
   parameter int unsigned WAYS   = 4,
   parameter int unsigned WORDS  = 16,
   parameter int unsigned WORD_W = 32,
   localparam int unsigned ROW_W  = $clog2(ROWS),
   localparam int unsigned WAY_W  = $clog2(WAYS),
   localparam int unsigned WOFF_W = $clog2(WORDS),
   localparam int unsigned LINE_W = WORDS*WORD_W
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   rd_en_i,
   input  logic [ROW_W-1:0]       rd_row_i,
   input  logic [WOFF_W-1:0]      rd_word_i,
   output logic [WAYS*WORD_W-1:0] rd_data_o,
   input  logic                   wr_en_i,
   input  logic [ROW_W-1:0]       wr_row_i,
   input  logic [WAY_W-1:0]       wr_way_i,
   input  logic [LINE_W-1:0]      wr_line_i
);
   logic [WORD_W-1:0] data_mem [ROWS*WAYS*WORDS];

   always_ff @(posedge clk_i) begin
      if (wr_en_i) begin
         for (int k = 0; k < WORDS; k++) begin
            data_mem[{wr_row_i, wr_way_i, WOFF_W'(k)}] <= wr_line_i[k*WORD_W +: WORD_W];
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         rd_data_o <= '0;
      end else if (rd_en_i) begin
         for (int w = 0; w < WAYS; w++) begin
            rd_data_o[w*WORD_W +: WORD_W] <= data_mem[{rd_row_i, WAY_W'(w), rd_word_i}];
         end
      end
   end
endmodule

// File: rtl/slice_cache_lookup.sv
module slice_cache_lookup
   import slc_pkg::*;
#(
   parameter int unsigned ADDR_W      = DEF_ADDR_W,
   parameter int unsigned CACHE_BYTES = DEF_CACHE_BYTES,
   parameter int unsigned LINE_BYTES  = DEF_LINE_BYTES,
   parameter int unsigned WAYS        = DEF_WAYS,
   parameter int unsigned WORD_W      = DEF_WORD_W,
   parameter int unsigned NUM_SUB     = DEF_NUM_SUB,
   localparam int unsigned WAY_W      = $clog2(WAYS),
   localparam int unsigned LINE_W     = LINE_BYTES*8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              req_valid_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic              fill_valid_i,
   input  logic [ADDR_W-1:0] fill_addr_i,
   input  logic [WAY_W-1:0]  fill_way_i,
   input  logic [LINE_W-1:0] fill_line_i,
   output logic              resp_valid_o,
   output logic              resp_hit_o,
   output logic              resp_miss_o,
   output logic [WORD_W-1:0] resp_data_o,
   output logic [NUM_SUB-1:0] tag_sub_en_o,
   output logic [NUM_SUB-1:0] data_sub_en_o
);
   // ---------------- derived geometry ----------------
   localparam int unsigned SETS     = CACHE_BYTES / (LINE_BYTES * WAYS);
   localparam int unsigned WORDS    = LINE_BYTES * 8 / WORD_W;
   localparam int unsigned BYTE_W   = $clog2(WORD_W / 8);
   localparam int unsigned WOFF_W   = $clog2(WORDS);
   localparam int unsigned OFF_W    = BYTE_W + WOFF_W;
   localparam int unsigned SET_W    = $clog2(SETS);
   localparam int unsigned SUB_W    = $clog2(NUM_SUB);
   localparam int unsigned ROWS     = SETS / NUM_SUB;
   localparam int unsigned ROW_W    = SET_W - SUB_W;
   localparam int unsigned TAG_W    = ADDR_W - SET_W - OFF_W;
   localparam int unsigned TAG_LO_W = TAG_W / 2;
   localparam int unsigned TAG_HI_W = TAG_W - TAG_LO_W;

   // ---------------- elaboration checks ----------------
   if (!is_pow2(WAYS) || WAYS < 2) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (!is_pow2(NUM_SUB) || NUM_SUB < 2) begin : g_bad_sub
      $error("NUM_SUB must be a power of two of at least 2");
   end
   if (!is_pow2(SETS) || SETS < 2*NUM_SUB) begin : g_bad_sets
      $error("set count must be a power of two holding two rows per subarray");
   end
   if (!is_pow2(WORDS) || WORD_W % 8 != 0 || WORD_W < 16) begin : g_bad_word
      $error("line must hold a power-of-two count of byte-multiple words");
   end
   if (TAG_W < 2) begin : g_bad_tag
      $error("address too narrow for a split tag");
   end

   // ---------------- request field split ----------------
   logic [SET_W-1:0]  req_set;
   logic [SUB_W-1:0]  req_sub;
   logic [ROW_W-1:0]  req_row;
   logic [WOFF_W-1:0] req_word;
   logic [TAG_W-1:0]  req_tag;
   logic [SET_W-1:0]  fill_set;
   logic [TAG_W-1:0]  fill_tag;
   logic              unused_bits;

   assign req_set     = req_addr_i[OFF_W +: SET_W];
   assign req_sub     = req_set[SUB_W-1:0];
   assign req_row     = req_set[SET_W-1:SUB_W];
   assign req_word    = req_addr_i[BYTE_W +: WOFF_W];
   assign req_tag     = req_addr_i[ADDR_W-1 -: TAG_W];
   assign fill_set    = fill_addr_i[OFF_W +: SET_W];
   assign fill_tag    = fill_addr_i[ADDR_W-1 -: TAG_W];
   assign unused_bits = ^{req_addr_i[BYTE_W-1:0], fill_addr_i[OFF_W-1:0]};

   // ---------------- stage 1: subarray decode ----------------
   logic [NUM_SUB-1:0] req_dec, fill_dec;

   slc_sub_decoder #(.N(NUM_SUB)) u_req_dec (
      .en_i (req_valid_i), .idx_i(req_sub), .sel_o(req_dec)
   );
   slc_sub_decoder #(.N(NUM_SUB)) u_fill_dec (
      .en_i (fill_valid_i), .idx_i(fill_set[SUB_W-1:0]), .sel_o(fill_dec)
   );

   logic               s1_vld;
   logic [NUM_SUB-1:0] s1_sel;
   logic [SUB_W-1:0]   s1_sub;
   logic [ROW_W-1:0]   s1_row;
   logic [WOFF_W-1:0]  s1_word;
   logic [TAG_W-1:0]   s1_tag;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         s1_vld <= 1'b0;
         s1_sel <= '0;
         s1_sub <= '0;
         s1_row <= '0;
         s1_word <= '0;
         s1_tag <= '0;
      end else begin
         s1_vld  <= req_valid_i;
         s1_sel  <= req_dec;
         s1_sub  <= req_sub;
         s1_row  <= req_row;
         s1_word <= req_word;
         s1_tag  <= req_tag;
      end
   end

   assign tag_sub_en_o = s1_sel;

   // ---------------- stage 2: row decode in one subarray, tag read ----------------
   logic [WAYS*TAG_W-1:0]  bank_tag  [NUM_SUB];
   logic [WAYS-1:0]        bank_vld  [NUM_SUB];
   logic [WAYS*WORD_W-1:0] bank_data [NUM_SUB];

   logic               s2_vld;
   logic [NUM_SUB-1:0] s2_sel;
   logic [SUB_W-1:0]   s2_sub;
   logic [ROW_W-1:0]   s2_row;
   logic [WOFF_W-1:0]  s2_word;
   logic [TAG_W-1:0]   s2_tag;

   for (genvar k = 0; k < NUM_SUB; k++) begin : g_sub
      slc_tag_bank #(.ROWS(ROWS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tag (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .rd_en_i (s1_sel[k]),
         .rd_row_i(s1_row),
         .rd_tag_o(bank_tag[k]),
         .rd_vld_o(bank_vld[k]),
         .wr_en_i (fill_dec[k]),
         .wr_row_i(fill_set[SET_W-1:SUB_W]),
         .wr_way_i(fill_way_i),
         .wr_tag_i(fill_tag)
      );
      slc_data_bank #(.ROWS(ROWS), .WAYS(WAYS), .WORDS(WORDS), .WORD_W(WORD_W)) u_data (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .rd_en_i  (s2_sel[k]),
         .rd_row_i (s2_row),
         .rd_word_i(s2_word),
         .rd_data_o(bank_data[k]),
         .wr_en_i  (fill_dec[k]),
         .wr_row_i (fill_set[SET_W-1:SUB_W]),
         .wr_way_i (fill_way_i),
         .wr_line_i(fill_line_i)
      );
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         s2_vld <= 1'b0;
         s2_sel <= '0;
         s2_sub <= '0;
         s2_row <= '0;
         s2_word <= '0;
         s2_tag <= '0;
      end else begin
         s2_vld  <= s1_vld;
         s2_sel  <= s1_sel;
         s2_sub  <= s1_sub;
         s2_row  <= s1_row;
         s2_word <= s1_word;
         s2_tag  <= s1_tag;
      end
   end

   assign data_sub_en_o = s2_sel;

   // ---------------- stage 3: data read + upper-half tag compare ----------------
   logic [WAYS*TAG_W-1:0]    cur_tag;
   logic [WAYS-1:0]          cur_vld;
   logic [WAYS*TAG_HI_W-1:0] cur_hi;
   logic [WAYS*TAG_LO_W-1:0] cur_lo;
   logic [WAYS-1:0]          part_match;

   always_comb begin
      cur_tag = bank_tag[s2_sub];
      cur_vld = bank_vld[s2_sub];
   end

   for (genvar w = 0; w < WAYS; w++) begin : g_split
      assign cur_hi[w*TAG_HI_W +: TAG_HI_W] = cur_tag[w*TAG_W + TAG_LO_W +: TAG_HI_W];
      assign cur_lo[w*TAG_LO_W +: TAG_LO_W] = cur_tag[w*TAG_W +: TAG_LO_W];
   end

   slc_way_cmp #(.WAYS(WAYS), .W(TAG_HI_W)) u_cmp_hi (
      .stored_i(cur_hi),
      .key_i   (s2_tag[TAG_W-1 -: TAG_HI_W]),
      .qual_i  (cur_vld),
      .match_o (part_match)
   );

   logic                     s3_vld;
   logic [SUB_W-1:0]         s3_sub;
   logic [WAYS-1:0]          s3_part;
   logic [WAYS*TAG_LO_W-1:0] s3_lo;
   logic [TAG_LO_W-1:0]      s3_key_lo;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         s3_vld <= 1'b0;
         s3_sub <= '0;
         s3_part <= '0;
         s3_lo <= '0;
         s3_key_lo <= '0;
      end else begin
         s3_vld    <= s2_vld;
         s3_sub    <= s2_sub;
         s3_part   <= part_match & {WAYS{s2_vld}};
         s3_lo     <= cur_lo;
         s3_key_lo <= s2_tag[TAG_LO_W-1:0];
      end
   end

   // ---------------- stage 4: completing compare + way select ----------------
   logic [WAYS*WORD_W-1:0] cur_words;
   logic [WAYS-1:0]        full_match;
   logic [WORD_W-1:0]      sel_word;
   logic                   any_hit;

   always_comb cur_words = bank_data[s3_sub];

   slc_way_cmp #(.WAYS(WAYS), .W(TAG_LO_W)) u_cmp_lo (
      .stored_i(s3_lo),
      .key_i   (s3_key_lo),
      .qual_i  (s3_part),
      .match_o (full_match)
   );

   always_comb begin
      sel_word = '0;
      for (int w = 0; w < WAYS; w++) begin
         sel_word = sel_word | (cur_words[w*WORD_W +: WORD_W] & {WORD_W{full_match[w]}});
      end
   end

   assign any_hit = |full_match;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         resp_valid_o <= 1'b0;
         resp_hit_o   <= 1'b0;
         resp_miss_o  <= 1'b0;
         resp_data_o  <= '0;
      end else begin
         resp_valid_o <= s3_vld;
         resp_hit_o   <= s3_vld && any_hit;
         resp_miss_o  <= s3_vld && !any_hit;
         resp_data_o  <= (s3_vld && any_hit) ? sel_word : '0;
      end
   end

   // ---------------- assertions ----------------
   logic [2:0] since_rst;
   always_ff @(posedge clk_i) begin
      if (!rst_ni)              since_rst <= '0;
      else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
   end

   a_r2_resp_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (since_rst >= 3'(LOOKUP_LATENCY)) |-> (resp_valid_o == $past(req_valid_i, 4)));

   a_r3_tag_en_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(tag_sub_en_o));

   a_r3_tag_en_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (since_rst >= 3'd1 && tag_sub_en_o != '0) |-> $past(req_valid_i));

   a_r4_data_en_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (since_rst >= 3'd1) |-> (data_sub_en_o == $past(tag_sub_en_o)));

   a_r5_single_way: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(full_match));

   a_r7_hit_xor_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
      resp_valid_o |-> (resp_hit_o != resp_miss_o));

   a_r7_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !resp_valid_o |-> (!resp_hit_o && !resp_miss_o));

   a_r7_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      resp_miss_o |-> (resp_data_o == '0));
endmodule

// File: tb/slice_cache_lookup_tb_top.sv
module slice_cache_lookup_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   logic         req_valid = 1'b0;
   logic [31:0]  req_addr = '0;
   logic         fill_valid = 1'b0;
   logic [31:0]  fill_addr = '0;
   logic [1:0]   fill_way = '0;
   logic [511:0] fill_line = '0;
   logic         resp_valid, resp_hit, resp_miss;
   logic [31:0]  resp_data;
   logic [3:0]   tag_en, data_en;

   slice_cache_lookup dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .req_valid_i(req_valid), .req_addr_i(req_addr),
      .fill_valid_i(fill_valid), .fill_addr_i(fill_addr),
      .fill_way_i(fill_way), .fill_line_i(fill_line),
      .resp_valid_o(resp_valid), .resp_hit_o(resp_hit), .resp_miss_o(resp_miss),
      .resp_data_o(resp_data), .tag_sub_en_o(tag_en), .data_sub_en_o(data_en)
   );

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   // reference model
   logic [20:0] m_tag  [32][4];
   bit          m_vld  [32][4];
   int unsigned m_seed [32][4];

   bit          eq_hit  [4096];
   logic [31:0] eq_data [4096];
   string       eq_req  [4096];
   int wp = 0, rp = 0;

   bit         vp1 = 0, vp2 = 0, vp3 = 0, vp4 = 0;
   logic [3:0] sub1 = '0, sub2 = '0;

   function automatic logic [31:0] word_of(input int unsigned seed, input int unsigned w);
      return (seed * 32'h9E3779B1) ^ (w * 32'h01000193) ^ 32'h5A00_00A5;
   endfunction

   function automatic logic [31:0] mk_addr(input logic [20:0] tag, input int unsigned set,
                                           input int unsigned word, input int unsigned byt);
      return {tag, set[4:0], word[3:0], byt[1:0]};
   endfunction

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   // One clock: check outputs, then drive the next inputs
   task automatic cyc(input bit rv, input logic [31:0] ra, input string rq,
                      input bit fv, input logic [31:0] fa, input logic [1:0] fw,
                      input int unsigned fseed);
      @(negedge clk);
      chk(tag_en == sub1, "R3", "tag_sub_en", 64'(tag_en), 64'(sub1));
      chk(data_en == sub2, "R4", "data_sub_en", 64'(data_en), 64'(sub2));
      chk(resp_valid == vp4, "R2", "resp_valid", 64'(resp_valid), 64'(vp4));
      if (resp_valid && rp < wp) begin
         chk(resp_hit == eq_hit[rp], eq_req[rp], "hit", 64'(resp_hit), 64'(eq_hit[rp]));
         chk(resp_miss == !eq_hit[rp], "R7", "miss", 64'(resp_miss), 64'(!eq_hit[rp]));
         chk(resp_data == eq_data[rp], eq_req[rp], "data", 64'(resp_data), 64'(eq_data[rp]));
         rp++;
      end else if (!resp_valid) begin
         chk(!resp_hit && !resp_miss, "R7", "idle flags", 64'({resp_hit, resp_miss}), 64'(0));
      end
      vp4 = vp3; vp3 = vp2; vp2 = vp1; vp1 = rv;
      sub2 = sub1;
      sub1 = rv ? (4'b0001 << ra[7:6]) : 4'b0000;
      if (fv) begin
         int unsigned s = fa[10:6];
         m_tag[s][fw] = fa[31:11];
         m_vld[s][fw] = 1'b1;
         m_seed[s][fw] = fseed;
         for (int k = 0; k < 16; k++) fill_line[32*k +: 32] = word_of(fseed, k);
      end
      if (rv) begin
         int unsigned s = ra[10:6];
         bit h = 1'b0;
         logic [31:0] d = '0;
         for (int w = 0; w < 4; w++) begin
            if (m_vld[s][w] && m_tag[s][w] == ra[31:11]) begin
               h = 1'b1;
               d = word_of(m_seed[s][w], ra[5:2]);
            end
         end
         eq_hit[wp] = h; eq_data[wp] = d; eq_req[wp] = rq;
         wp++;
      end
      req_valid = rv; req_addr = ra;
      fill_valid = fv; fill_addr = fa; fill_way = fw;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(0, '0, "R2", 0, '0, '0, 0);
   endtask

   function automatic logic [20:0] base_tag(input int unsigned s, input int unsigned w);
      return 21'((s * 4 + w) * 32'h1357 + 32'h100);
   endfunction

   initial begin
      for (int s = 0; s < 32; s++)
         for (int w = 0; w < 4; w++) m_vld[s][w] = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state at the ports
      chk(!resp_valid && !resp_hit && !resp_miss && resp_data == 0 && tag_en == 0 && data_en == 0,
          "R1", "reset outputs", 64'({resp_valid, resp_hit, resp_miss, tag_en, data_en}), 64'(0));

      // R1: every set misses before any fill, lookups back to back
      for (int s = 0; s < 32; s++) cyc(1, mk_addr(base_tag(s, s % 4), s, s % 16, 0), "R1", 0, '0, '0, 0);
      idle(5);

      // R8: fill every line of the cache
      for (int s = 0; s < 32; s++)
         for (int w = 0; w < 4; w++)
            cyc(0, '0, "R8", 1, mk_addr(base_tag(s, w), s, 0, 0), 2'(w), s * 4 + w + 1);
      idle(1);

      // R5/R9: sweep sets, ways and word offsets with varying byte offsets
      for (int s = 0; s < 32; s++)
         for (int w = 0; w < 4; w++) begin
            cyc(1, mk_addr(base_tag(s, w), s, 0, s % 4), "R5", 0, '0, '0, 0);
            cyc(1, mk_addr(base_tag(s, w), s, 15, 3), "R9", 0, '0, '0, 0);
            cyc(1, mk_addr(base_tag(s, w), s, (s + w) % 16, w), "R5", 0, '0, '0, 0);
         end
      idle(5);

      // R6: only one half of the tag matches
      for (int s = 0; s < 32; s++)
         for (int w = 0; w < 4; w++) begin
            cyc(1, mk_addr(base_tag(s, w) ^ 21'h000200, s, w, 0), "R6", 0, '0, '0, 0);
            cyc(1, mk_addr(base_tag(s, w) ^ 21'h100000, s, w, 0), "R6", 0, '0, '0, 0);
         end
      idle(5);

      // R8: overwrite, then look up in the very next cycle
      cyc(0, '0, "R8", 1, mk_addr(21'h0ABCDE, 5, 0, 0), 2'd2, 777);
      cyc(1, mk_addr(21'h0ABCDE, 5, 7, 0), "R8", 0, '0, '0, 0);
      cyc(1, mk_addr(base_tag(5, 2), 5, 7, 0), "R8", 0, '0, '0, 0);

      // R8: lookup to way 0 in flight while way 1 of the same set is replaced
      cyc(1, mk_addr(base_tag(9, 0), 9, 3, 0), "R8", 0, '0, '0, 0);
      cyc(0, '0, "R8", 1, mk_addr(21'h155555, 9, 0, 0), 2'd1, 4242);
      cyc(1, mk_addr(21'h155555, 9, 12, 0), "R8", 0, '0, '0, 0);
      cyc(1, mk_addr(base_tag(9, 1), 9, 12, 0), "R8", 0, '0, '0, 0);
      cyc(1, mk_addr(base_tag(9, 0), 9, 3, 2), "R8", 0, '0, '0, 0);

      // R2: interleave gaps between requests
      for (int i = 0; i < 24; i++) begin
         if (i % 3 == 0) cyc(0, '0, "R2", 0, '0, '0, 0);
         else cyc(1, mk_addr(base_tag(i, i % 4), i, i % 16, 0), "R2", 0, '0, '0, 0);
      end
      idle(6);
      chk(rp == wp, "R2", "responses returned", 64'(rp), 64'(wp));

      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      #(8 * 150000);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule